// File: doc/BRIEF.md
# Peak Magnitude Bin Tracker

This block sits behind a spectrum engine that emits one signed magnitude per frequency bin. It follows the stream frame by frame and keeps a running maximum together with the position of that maximum. When a frame closes, it copies the winning bin position into a register that host software can read. A frame is bounded by a start strobe on its first sample and an end strobe on its last sample. Both strobes count only on cycles where the sample is valid.

The published register changes only when a frame has been searched all the way through. A frame that is cut short produces no result and leaves the register holding the last complete answer. A frame is cut short by a synchronous clear, by a new start strobe, or by running past the frame length. Software can therefore read the register at any moment and never sees a half-finished search.

Top module: `peak_bin_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, `peak_idx` reads 0 until the first frame completes.
- R2: After a frame completes, `peak_idx` holds the zero-based position, counted in accepted samples from the start strobe, of the sample with the largest magnitude in that frame. Magnitudes are compared as two's-complement signed values, so negative magnitudes rank below positive ones.
- R3: When several samples share the maximum value, the earliest position wins.
- R4: `peak_idx` takes its new value in the cycle after the end-strobe sample is accepted. In every cycle that does not follow an accepted end-strobe sample, it keeps its value.
- R5: Each start strobe reloads the search from its own sample. The magnitudes of an earlier frame never affect the result of a later frame.
- R6: A start strobe inside an open frame drops the partial search and begins a new frame at position 0.
- R7: `clr` drops any open frame and does not change `peak_idx`. A sample offered in the same cycle as `clr` is ignored, including its strobes.
- R8: Only cycles with `mag_valid` high advance the bin position. Strobes and data on cycles with `mag_valid` low have no effect.
- R9: Valid samples and end strobes that arrive while no frame is open are ignored.
- R10: A sample that carries both the start and the end strobe forms a one-bin frame and publishes position 0.
- R11: A frame holds at most NBINS samples, so an end strobe on position NBINS-1 publishes normally. If a further sample arrives without an intervening start strobe, the frame is dropped unpublished, and so is any end strobe that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the search in progress |
| mag_valid | input | 1 | Sample qualifier |
| mag_sof | input | 1 | First sample of a frame |
| mag_eof | input | 1 | Last sample of a frame |
| mag_data | input | MAG_W (17) | Signed bin magnitude |
| peak_idx | output | IDX_W (11) | Position of the peak in the last completed frame |

## Verification
The hardest case to reach from the ports is a frame that is dropped while a large value is held in its partial search. The dropped value must not leak into the published register or into the next frame. The stimulus plants a magnitude larger than anything that follows, then drops the frame in three separate ways: a clear, an early restart, and an overrun past the frame length. In each case the next complete frame must report its own smaller peak. The bench is built with a small frame length so that the boundary at the last bin and the overrun just past it take only a few cycles each to reach.

// File: rtl/peak_pkg.sv
package peak_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_OPEN = 1'b1
  } frame_state_e;
endpackage

// File: rtl/peak_bin_ctr.sv
module peak_bin_ctr
  import peak_pkg::*;
#(
  parameter  int NBINS = 2048,
  localparam int IDX_W = $clog2(NBINS),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             smp_v,
  input  logic             smp_sof,
  input  logic             smp_eof,
  output logic             take,
  output logic             first,
  output logic             done,
  output logic [IDX_W-1:0] cur_idx,
  output logic             open_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(NBINS);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  frame_state_e     st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             start, cont, ovr, room, is_open;

  always_comb begin
    is_open = (st_q == FS_OPEN);
    room    = (cnt_q < CNT_LIM);
    start   = smp_v & smp_sof & ~clr;
    cont    = smp_v & ~smp_sof & ~clr & is_open & room;
    ovr     = smp_v & ~smp_sof & ~clr & is_open & ~room;
    st_d    = st_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (clr) begin
      st_d = FS_IDLE;
    end else if (start) begin
      st_d   = smp_eof ? FS_IDLE : FS_OPEN;
      cnt_d  = CNT_ONE;
      cnt_en = 1'b1;
    end else if (cont) begin
      st_d   = smp_eof ? FS_IDLE : FS_OPEN;
      cnt_d  = cnt_q + CNT_ONE;
      cnt_en = 1'b1;
    end else if (ovr) begin
      st_d = FS_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FS_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_comb begin
    take    = start | cont;
    first   = start;
    done    = (start | cont) & smp_eof;
    cur_idx = start ? '0 : cnt_q[IDX_W-1:0];
    open_o  = is_open;
    cnt_o   = cnt_q;
  end
endmodule

// File: rtl/peak_run_max.sv
module peak_run_max #(
  parameter int MAG_W = 17,
  parameter int IDX_W = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    first,
  input  logic signed [MAG_W-1:0] cur_mag,
  input  logic [IDX_W-1:0]        cur_idx,
  output logic [IDX_W-1:0]        win_idx
);
  logic signed [MAG_W-1:0] best_mag_q, best_mag_d;
  logic [IDX_W-1:0]        best_idx_q, best_idx_d;
  logic                    beat, best_en;

  always_comb begin
    beat       = first | (cur_mag > best_mag_q);
    best_en    = take & beat;
    best_mag_d = cur_mag;
    best_idx_d = cur_idx;
    win_idx    = beat ? cur_idx : best_idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_mag_q <= '0;
      best_idx_q <= '0;
    end else if (best_en) begin
      best_mag_q <= best_mag_d;
      best_idx_q <= best_idx_d;
    end
  end
endmodule

// File: rtl/peak_pub_reg.sv
module peak_pub_reg #(
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [IDX_W-1:0] d,
  output logic [IDX_W-1:0] q
);
  logic [IDX_W-1:0] q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else if (ld) begin
      q_r <= d;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/peak_bin_tracker.sv
module peak_bin_tracker #(
  parameter  int NBINS = 2048,
  parameter  int MAG_W = 17,
  localparam int IDX_W = $clog2(NBINS),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    mag_valid,
  input  logic                    mag_sof,
  input  logic                    mag_eof,
  input  logic signed [MAG_W-1:0] mag_data,
  output logic [IDX_W-1:0]        peak_idx
);
  logic             s_take, s_first, s_done;
  logic [IDX_W-1:0] s_idx, s_win;
  logic             frame_open;
  logic [CNT_W-1:0] ctr_cnt;

  peak_bin_ctr #(.NBINS(NBINS)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .smp_v   (mag_valid),
    .smp_sof (mag_sof),
    .smp_eof (mag_eof),
    .take    (s_take),
    .first   (s_first),
    .done    (s_done),
    .cur_idx (s_idx),
    .open_o  (frame_open),
    .cnt_o   (ctr_cnt)
  );

  peak_run_max #(.MAG_W(MAG_W), .IDX_W(IDX_W)) u_max (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (s_take),
    .first   (s_first),
    .cur_mag (mag_data),
    .cur_idx (s_idx),
    .win_idx (s_win)
  );

  peak_pub_reg #(.IDX_W(IDX_W)) u_pub (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (s_done),
    .d     (s_win),
    .q     (peak_idx)
  );
endmodule

// File: rtl/peak_bin_tracker_chk.sv
module peak_bin_tracker_chk #(
  parameter  int NBINS = 2048,
  localparam int IDX_W = $clog2(NBINS),
  localparam int CNT_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             mag_valid,
  input logic             mag_sof,
  input logic             mag_eof,
  input logic [IDX_W-1:0] peak_idx,
  input logic             frame_open,
  input logic [CNT_W-1:0] ctr_cnt
);
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(NBINS);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mag_valid && mag_eof) |=> $stable(peak_idx));

  p_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_valid && mag_eof && !clr) |=> !frame_open);

  p_clr_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ($stable(peak_idx) && !frame_open));

  p_stray_eof_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_valid && mag_eof && !mag_sof && !frame_open) |=> $stable(peak_idx));

  p_single_bin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mag_valid && mag_sof && mag_eof && !clr) |=> (peak_idx == '0));

  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_open |-> (ctr_cnt <= CNT_LIM));
endmodule

bind peak_bin_tracker peak_bin_tracker_chk #(.NBINS(NBINS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .mag_valid  (mag_valid),
  .mag_sof    (mag_sof),
  .mag_eof    (mag_eof),
  .peak_idx   (peak_idx),
  .frame_open (frame_open),
  .ctr_cnt    (ctr_cnt)
);

// File: tb/sim_peak_bin_tracker.sv
module sim_peak_bin_tracker;
  localparam int N  = 16;
  localparam int MW = 17;
  localparam int IW = $clog2(N);

  logic          clk, rst_n, clr, mag_valid, mag_sof, mag_eof;
  logic [MW-1:0] mag_data;
  logic [IW-1:0] peak_idx;

  int checks = 0;
  int errors = 0;
  bit done_f = 0;
  string tag = "R1";
  int q[$];

  // reference model state
  bit m_open;
  int m_cnt, m_best, m_bi, m_pub;

  peak_bin_tracker #(.NBINS(N), .MAG_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mag_valid(mag_valid),
    .mag_sof(mag_sof), .mag_eof(mag_eof), .mag_data(mag_data),
    .peak_idx(peak_idx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_open = 0; m_cnt = 0; m_best = 0; m_bi = 0; m_pub = 0;
    end else if (clr) begin
      m_open = 0;
    end else if (mag_valid) begin
      int d;
      d = $signed(mag_data);
      if (mag_sof) begin
        m_best = d; m_bi = 0; m_cnt = 1; m_open = 1;
        if (mag_eof) begin m_pub = 0; m_open = 0; end
      end else if (m_open) begin
        if (m_cnt >= N) m_open = 0;
        else begin
          if (d > m_best) begin m_best = d; m_bi = m_cnt; end
          if (mag_eof) begin m_pub = m_bi; m_open = 0; end
          m_cnt++;
        end
      end
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic s, input logic e, input int d);
    @(negedge clk);
    chk({tag, " model"}, int'(peak_idx), m_pub);
    mag_valid = v; mag_sof = s; mag_eof = e; mag_data = d[MW-1:0];
  endtask

  task automatic idle(); step(0, 0, 0, 0); endtask

  // sends q as one frame; gap invalid cycles (with junk) after each sample
  task automatic send(input int gap, input bit with_eof);
    foreach (q[i]) begin
      step(1, i == 0, with_eof && (i == q.size() - 1), q[i]);
      for (int g = 0; g < gap; g++) step(0, 1, 1, 60000);
    end
  endtask

  task automatic fill(input int base, input int pk_at, input int pk);
    q = {};
    for (int i = 0; i < N; i++) q.push_back(i == pk_at ? pk : base + i);
  endtask

  initial begin
    rst_n = 0; clr = 0; mag_valid = 0; mag_sof = 0; mag_eof = 0; mag_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", int'(peak_idx), 0);
    rst_n = 1;
    idle(); idle();
    chk("R1 after reset", int'(peak_idx), 0);

    tag = "R2";
    fill(10, 9, 5000); send(0, 1); idle();
    chk("R2 positive peak", int'(peak_idx), 9);
    q = {};
    for (int i = 0; i < N; i++) q.push_back(i == 12 ? -3 : -100 - i);
    send(0, 1); idle();
    chk("R2 signed all-negative", int'(peak_idx), 12);

    tag = "R3";
    fill(0, 2, 700); q[11] = 700; send(0, 1); idle();
    chk("R3 tie earliest", int'(peak_idx), 2);

    tag = "R4";
    fill(0, 4, 900); q = q[0:N-2]; send(0, 0);
    chk("R4 before end", int'(peak_idx), 2);
    step(1, 0, 1, 1);
    chk("R4 same cycle as end", int'(peak_idx), 2);
    idle();
    chk("R4 cycle after end", int'(peak_idx), 4);
    repeat (5) idle();
    chk("R4 holds", int'(peak_idx), 4);

    tag = "R5";
    fill(0, 3, 60000); send(0, 1); idle();
    chk("R5 big frame", int'(peak_idx), 3);
    fill(0, 7, 50); send(0, 1); idle();
    chk("R5 reload", int'(peak_idx), 7);

    tag = "R6";
    q = '{1, 65000, 2}; send(0, 0);
    fill(0, 5, 300); send(0, 1); idle();
    chk("R6 restart", int'(peak_idx), 5);

    tag = "R7";
    q = '{1, 2, 3, 65000}; send(0, 0);
    @(negedge clk); clr = 1; mag_valid = 0;
    @(negedge clk); clr = 0;
    step(1, 0, 1, 9); idle();
    chk("R7 clr keeps reg", int'(peak_idx), 5);
    @(negedge clk); clr = 1; mag_valid = 1; mag_sof = 1; mag_eof = 1; mag_data = 17'd5;
    @(negedge clk); clr = 0; mag_valid = 0; mag_sof = 0; mag_eof = 0;
    idle();
    chk("R7 sample with clr ignored", int'(peak_idx), 5);
    fill(0, 11, 400); send(0, 1); idle();
    chk("R7 clean frame after clr", int'(peak_idx), 11);

    tag = "R8";
    fill(0, 6, 800); send(2, 1); idle();
    chk("R8 gaps not counted", int'(peak_idx), 6);

    tag = "R9";
    step(1, 0, 1, 65000); step(1, 0, 0, 65000); idle();
    chk("R9 stray ignored", int'(peak_idx), 6);

    tag = "R10";
    step(1, 1, 1, -7); idle();
    chk("R10 one-bin frame", int'(peak_idx), 0);

    tag = "R11";
    fill(0, N - 1, 999); send(0, 1); idle();
    chk("R11 last bin", int'(peak_idx), N - 1);
    fill(0, 2, 999); q.push_back(5); send(0, 1); idle();
    chk("R11 overrun dropped", int'(peak_idx), N - 1);
    fill(0, 2, 999); q.push_back(5); send(0, 0); step(1, 0, 1, 1); idle();
    chk("R11 late eof dropped", int'(peak_idx), N - 1);
    fill(0, 8, 30); send(0, 1); idle();
    chk("R11 recovers", int'(peak_idx), 8);

    done_f = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_f) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule